// File: doc/BRIEF.md
# Two-Channel Serial Port with Shared Status Word

This block holds two independent asynchronous serial channels behind a small register bus. Each channel sends through a one-byte holding register that feeds a shift register, and receives into a one-byte buffer that latches framing, parity and overrun faults. Software writes a channel's data register to queue a byte. It reads the same register to collect the byte last received.

Both channels report through one 32-bit status word. Channel A uses the low byte and channel B uses the same layout 16 bits higher. Each channel's latched faults are cleared by writing 1 to that channel's clear bit in the status word. Each channel drives its own event pulse for receive and transmit progress, and both channels share one level error line.

A frame is one low start bit, eight data bits sent least significant first, one parity bit and one high stop bit. Each bit lasts `CLK_DIV` clock cycles. `PARITY_ODD` selects even parity (0) or odd parity (1).

Top module: `duart_top`

## Requirements
- R1: Byte offset 0xE0 selects channel A data, 0xE4 selects channel B data and 0xE8 selects the status word. Any other offset reads as zero, and a write to any other offset changes no state and starts no transmission.
- R2: After reset the status word reads 0x00060006, both serial outputs are high, and all three interrupt lines are low.
- R3: A byte written to a channel's data register leaves on that channel's serial output as a complete frame. The frame is a low start bit, then data bits LSB first, then a parity bit (XOR of the data when PARITY_ODD=0, its inverse when 1), then a high stop bit. Each bit lasts CLK_DIV cycles.
- R4: In a channel's status field, bit 2 (holding empty) clears on a data write and sets again when the byte moves into the shifter. Bit 1 (shift empty) is low while a frame is being sent. The channel is fully idle only when both bits are 1.
- R5: A received byte appears in bits 7:0 of the channel data register, with the upper bits zero, and sets bit 0 (data ready). Reading the data register clears bit 0.
- R6: A frame whose stop bit is sampled low sets bit 4 (framing error). The byte is still stored.
- R7: A frame whose parity bit disagrees with the selected parity sets bit 5 (parity error).
- R8: A byte that completes while data ready is still set sets bit 6 (overrun), and the new byte replaces the old one.
- R9: Writing 1 to bit 7 of the status word clears channel A's bits 6:4, and writing 1 to bit 23 clears channel B's bits 22:20. Each clear leaves the other channel untouched. A status write without the clear bit clears nothing.
- R10: Channel B's status field has channel A's layout shifted up 16 bits.
- R11: A channel's event line pulses for one cycle each time a byte is received and each time its holding register passes a byte to the shifter.
- R12: The error line is high while any latched error bit is set in either channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a read of a data register consumes the byte) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ser_rx_a | input | 1 | Channel A serial input |
| ser_tx_a | output | 1 | Channel A serial output |
| ser_rx_b | input | 1 | Channel B serial input |
| ser_tx_b | output | 1 | Channel B serial output |
| irq_a | output | 1 | Channel A receive/transmit event pulse |
| irq_b | output | 1 | Channel B receive/transmit event pulse |
| irq_err | output | 1 | Shared error level |

## Verification
The hardest state to reach from the ports is the one where both channels hold different latched faults at the same time. Only then can one clear be shown to spare the other channel and to leave the shared error line up. The bench reaches it by driving a frame with deliberately wrong parity into channel B. It then sends two back-to-back frames into channel A without reading between them, which forces an overrun. The channel A clear is issued only after both faults are visible in the status word. Transmission is swept over all 256 byte values on channel A, and reception is swept over all 256 values with parity computed in the bench.

// File: rtl/duart_pkg.sv
// Package: shared types and register offsets for the two-channel serial port.
// Assumes 8-bit register offsets on a 32-bit data bus.
package duart_pkg;

    localparam logic [7:0] OFS_DATA_A = 8'hE0;
    localparam logic [7:0] OFS_DATA_B = 8'hE4;
    localparam logic [7:0] OFS_STAT   = 8'hE8;
    localparam int         CH_SHIFT   = 16;   // channel B field offset in the status word
    localparam int         CLR_BIT    = 7;    // clear bit inside a channel field
    localparam int         FRAME_BITS = 11;   // start + 8 data + parity + stop

    // Per-channel status field, bit 0 at the right.
    typedef struct packed {
        logic clr;        // bit 7: write-only clear, reads 0
        logic ovr;        // bit 6
        logic par;        // bit 5
        logic frm;        // bit 4
        logic rsv;        // bit 3
        logic hold_empty; // bit 2
        logic shft_empty; // bit 1
        logic rdy;        // bit 0
    } chan_stat_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI
    } rx_state_t;

endpackage

// File: rtl/duart_tx.sv
// Module: transmitter with a one-byte holding register feeding a frame shifter.
// Assumes CLK_DIV >= 4. A write while the holding register is full overwrites it.
module duart_tx #(
    parameter int CLK_DIV    = 8,
    parameter bit PARITY_ODD = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    output logic       ser_tx,
    output logic       hold_empty,
    output logic       shft_empty,
    output logic       xfer
);
    import duart_pkg::*;
    localparam int CW = $clog2(CLK_DIV);
    localparam int BW = $clog2(FRAME_BITS + 1);

    logic [7:0]            hold_q;
    logic                  hold_empty_q;
    logic                  busy_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic [BW-1:0]         bits_q;
    logic [CW-1:0]         baud_q;
    logic                  load;

    assign load = !hold_empty_q && !busy_q;

    // Holding register: filled by the bus, emptied by a load into the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q       <= '0;
            hold_empty_q <= 1'b1;
        end else if (wr_en) begin
            hold_q       <= wr_byte;
            hold_empty_q <= 1'b0;
        end else if (load) begin
            hold_empty_q <= 1'b1;
        end
    end

    // Frame shifter: emits one frame bit every CLK_DIV cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            shreg_q <= '1;
            bits_q  <= '0;
            baud_q  <= '0;
        end else if (load) begin
            busy_q  <= 1'b1;
            shreg_q <= {1'b1, (^hold_q) ^ PARITY_ODD, hold_q, 1'b0};
            bits_q  <= BW'(FRAME_BITS);
            baud_q  <= CW'(CLK_DIV - 1);
        end else if (busy_q) begin
            if (baud_q == '0) begin
                baud_q  <= CW'(CLK_DIV - 1);
                shreg_q <= {1'b1, shreg_q[FRAME_BITS-1:1]};
                bits_q  <= bits_q - 1'b1;
                if (bits_q == BW'(1)) busy_q <= 1'b0;
            end else begin
                baud_q <= baud_q - 1'b1;
            end
        end
    end

    assign ser_tx     = busy_q ? shreg_q[0] : 1'b1;
    assign hold_empty = hold_empty_q;
    assign shft_empty = !busy_q;
    assign xfer       = load;

    // R4
    shift_start_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(!hold_empty_q));
    // R3
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ser_tx);
endmodule

// File: rtl/duart_rx.sv
// Module: receiver that samples each bit at mid-bit and checks stop and parity.
// Assumes CLK_DIV >= 4. After a low stop bit it waits for the line to go high.
module duart_rx #(
    parameter int CLK_DIV    = 8,
    parameter bit PARITY_ODD = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_rx,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       frm_err,
    output logic       par_err
);
    import duart_pkg::*;
    localparam int CW = $clog2(CLK_DIV);

    logic            s1_q, s2_q;
    rx_state_t       st_q;
    logic [CW-1:0]   baud_q;
    logic [2:0]      bitn_q;
    logic [7:0]      sh_q;
    logic            pbit_q;

    // Two-stage synchroniser for the asynchronous serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= ser_rx;
            s2_q <= s1_q;
        end
    end

    // Frame state machine: start check, data, parity, stop, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RX_IDLE;
            baud_q  <= '0;
            bitn_q  <= '0;
            sh_q    <= '0;
            pbit_q  <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
            frm_err <= 1'b0;
            par_err <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                RX_IDLE: if (!s2_q) begin
                    st_q   <= RX_START;
                    baud_q <= CW'(CLK_DIV / 2 - 1);
                end
                RX_START: if (baud_q == '0) begin
                    baud_q <= CW'(CLK_DIV - 1);
                    bitn_q <= '0;
                    st_q   <= s2_q ? RX_IDLE : RX_DATA;
                end else baud_q <= baud_q - 1'b1;
                RX_DATA: if (baud_q == '0) begin
                    baud_q <= CW'(CLK_DIV - 1);
                    sh_q   <= {s2_q, sh_q[7:1]};
                    bitn_q <= bitn_q + 1'b1;
                    if (bitn_q == 3'd7) st_q <= RX_PAR;
                end else baud_q <= baud_q - 1'b1;
                RX_PAR: if (baud_q == '0) begin
                    baud_q <= CW'(CLK_DIV - 1);
                    pbit_q <= s2_q;
                    st_q   <= RX_STOP;
                end else baud_q <= baud_q - 1'b1;
                RX_STOP: if (baud_q == '0) begin
                    done    <= 1'b1;
                    rx_byte <= sh_q;
                    frm_err <= !s2_q;
                    par_err <= ((^sh_q) ^ pbit_q) != PARITY_ODD;
                    st_q    <= s2_q ? RX_IDLE : RX_WAITHI;
                end else baud_q <= baud_q - 1'b1;
                RX_WAITHI: if (s2_q) st_q <= RX_IDLE;
                default: st_q <= RX_IDLE;
            endcase
        end
    end

    // R6
    result_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(st_q == RX_STOP));
endmodule

// File: rtl/duart_chan.sv
// Module: one channel, with transmitter, receiver, receive buffer and latched faults.
// Assumes data_rd is a one-cycle strobe per bus read. A new fault wins over a clear in the same cycle.
module duart_chan #(
    parameter int CLK_DIV    = 8,
    parameter bit PARITY_ODD = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   data_wr,
    input  logic                   data_rd,
    input  logic [7:0]             wdata,
    input  logic                   clr_err,
    input  logic                   ser_rx,
    output logic                   ser_tx,
    output logic [7:0]             rbuf,
    output duart_pkg::chan_stat_t  stat,
    output logic                   evt,
    output logic                   rx_evt,
    output logic                   err
);
    logic       hold_empty, shft_empty, xfer;
    logic       rx_done, rx_frm, rx_par;
    logic [7:0] rx_byte;
    logic       rdy_q, frm_q, par_q, ovr_q;

    duart_tx #(.CLK_DIV(CLK_DIV), .PARITY_ODD(PARITY_ODD)) tx_i (
        .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .wr_byte(wdata),
        .ser_tx(ser_tx), .hold_empty(hold_empty), .shft_empty(shft_empty), .xfer(xfer)
    );

    duart_rx #(.CLK_DIV(CLK_DIV), .PARITY_ODD(PARITY_ODD)) rx_i (
        .clk(clk), .rst_n(rst_n), .ser_rx(ser_rx), .done(rx_done),
        .rx_byte(rx_byte), .frm_err(rx_frm), .par_err(rx_par)
    );

    // Receive buffer and data-ready flag; a read consumes the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf  <= '0;
            rdy_q <= 1'b0;
        end else if (rx_done) begin
            rbuf  <= rx_byte;
            rdy_q <= 1'b1;
        end else if (data_rd) begin
            rdy_q <= 1'b0;
        end
    end

    // Latched fault flags: cleared by the clear bit, set by a finished frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_q <= 1'b0;
            par_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            frm_q <= (frm_q && !clr_err) || (rx_done && rx_frm);
            par_q <= (par_q && !clr_err) || (rx_done && rx_par);
            ovr_q <= (ovr_q && !clr_err) || (rx_done && rdy_q && !data_rd);
        end
    end

    assign stat   = '{clr: 1'b0, ovr: ovr_q, par: par_q, frm: frm_q, rsv: 1'b0,
                      hold_empty: hold_empty, shft_empty: shft_empty, rdy: rdy_q};
    assign evt    = rx_done || xfer;
    assign rx_evt = rx_done;
    assign err    = frm_q || par_q || ovr_q;

    // R5
    byte_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rdy_q);
    // R8
    overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(rdy_q));
    // R9
    clear_empties_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !rx_done) |=> !(frm_q || par_q || ovr_q));
    // R4
    hold_fill_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_empty) |-> $past(data_wr));
endmodule

// File: rtl/duart_top.sv
// Module: register decode and status word packing for two serial channels.
// Assumes single-cycle wr/rd strobes. Read data is combinational on reg_addr.
module duart_top #(
    parameter int CLK_DIV    = 8,
    parameter bit PARITY_ODD = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ser_rx_a,
    output logic        ser_tx_a,
    input  logic        ser_rx_b,
    output logic        ser_tx_b,
    output logic        irq_a,
    output logic        irq_b,
    output logic        irq_err
);
    import duart_pkg::*;
    localparam int NCH = 2;

    logic [NCH-1:0]  rx_v, tx_v, evt_v, rxevt_v, err_v, sel_v;
    logic [7:0]      rbuf_v [NCH];
    chan_stat_t      stat_v [NCH];
    logic            sel_st;
    logic [31:0]     stat_word;

    assign rx_v     = {ser_rx_b, ser_rx_a};
    assign sel_v[0] = (reg_addr == OFS_DATA_A);
    assign sel_v[1] = (reg_addr == OFS_DATA_B);
    assign sel_st   = (reg_addr == OFS_STAT);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        duart_chan #(.CLK_DIV(CLK_DIV), .PARITY_ODD(PARITY_ODD)) chan_i (
            .clk(clk), .rst_n(rst_n),
            .data_wr(reg_wr && sel_v[c]),
            .data_rd(reg_rd && sel_v[c]),
            .wdata(reg_wdata[7:0]),
            .clr_err(reg_wr && sel_st && reg_wdata[c*CH_SHIFT + CLR_BIT]),
            .ser_rx(rx_v[c]), .ser_tx(tx_v[c]),
            .rbuf(rbuf_v[c]), .stat(stat_v[c]),
            .evt(evt_v[c]), .rx_evt(rxevt_v[c]), .err(err_v[c])
        );
    end

    assign stat_word = {8'h00, stat_v[1], 8'h00, stat_v[0]};

    // Read mux: data registers, status word, zero elsewhere.
    always_comb begin
        if (sel_v[0])      reg_rdata = {24'h0, rbuf_v[0]};
        else if (sel_v[1]) reg_rdata = {24'h0, rbuf_v[1]};
        else if (sel_st)   reg_rdata = stat_word;
        else               reg_rdata = '0;
    end

    assign ser_tx_a = tx_v[0];
    assign ser_tx_b = tx_v[1];
    assign irq_a    = evt_v[0];
    assign irq_b    = evt_v[1];
    assign irq_err  = |err_v;

    // R12
    err_rises_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_err) |-> $past(|rxevt_v));
endmodule

// File: tb/duart_top_tb.sv
module duart_top_tb_top;
    localparam int DIV = 8;
    localparam bit PODD = 1'b0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_a = 1'b1, rx_b = 1'b1;
    logic        ser_tx_a, ser_tx_b, irq_a, irq_b, irq_err;
    int          n_tot = 0, n_fail = 0, cnt_a = 0, cnt_b = 0;
    bit          done_flag = 1'b0;

    always #4 clk = ~clk;

    duart_top #(.CLK_DIV(DIV), .PARITY_ODD(PODD)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ser_rx_a(rx_a), .ser_tx_a(ser_tx_a), .ser_rx_b(rx_b), .ser_tx_b(ser_tx_b),
        .irq_a(irq_a), .irq_b(irq_b), .irq_err(irq_err)
    );

    always @(posedge clk) begin
        if (rst_n && irq_a) cnt_a++;
        if (rst_n && irq_b) cnt_b++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tot++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; #1 d = reg_rdata;
    endtask

    function automatic logic txline(input int ch);
        return ch == 0 ? ser_tx_a : ser_tx_b;
    endfunction

    task automatic grab(input int ch, output logic [10:0] fr);
        @(negedge clk);
        while (txline(ch) !== 1'b0) @(negedge clk);
        repeat (DIV / 2) @(negedge clk);
        for (int i = 0; i < 11; i++) begin
            fr[i] = txline(ch);
            if (i < 10) repeat (DIV) @(negedge clk);
        end
    endtask

    task automatic send(input int ch, input logic [7:0] b, input bit badpar, input bit badstop);
        logic [10:0] f;
        f = {~badstop, (^b) ^ PODD ^ badpar, b, 1'b0};
        for (int i = 0; i < 11; i++) begin
            if (ch == 0) rx_a = f[i]; else rx_b = f[i];
            repeat (DIV) @(negedge clk);
        end
        rx_a = 1'b1; rx_b = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [10:0] frame_of(input logic [7:0] b);
        return {1'b1, (^b) ^ PODD, b, 1'b0};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_tot++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2;
        logic [10:0] fr, fr2;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        peek(8'hE8, d);
        chk(d == 32'h00060006, "R2 status", d, 32'h00060006);
        chk({ser_tx_a, ser_tx_b, irq_a, irq_b, irq_err} == 5'b11000, "R2 lines",
            {27'h0, ser_tx_a, ser_tx_b, irq_a, irq_b, irq_err}, 32'h18);

        // R3 / R11: exhaustive transmit sweep on channel A
        base = cnt_a;
        for (int v = 0; v < 256; v++) begin
            bus_write(8'hE0, 32'(v));
            grab(0, fr);
            chk(fr == frame_of(8'(v)), "R3 frame A", {21'h0, fr}, {21'h0, frame_of(8'(v))});
        end
        repeat (2 * DIV) @(negedge clk);
        chk(cnt_a - base == 256, "R11 tx events A", 32'(cnt_a - base), 32'd256);

        // R4 / R10: holding and shift flags on channel B with back-to-back writes
        fork
            begin
                bus_write(8'hE4, 32'hA5);
                peek(8'hE8, d);
                chk(d[18:16] == 3'b010, "R4 after write", {29'h0, d[18:16]}, 32'h2);
                @(negedge clk); peek(8'hE8, d);
                chk(d[18:16] == 3'b100, "R4 after load", {29'h0, d[18:16]}, 32'h4);
                bus_write(8'hE4, 32'h3C);
                peek(8'hE8, d);
                chk(d[18:16] == 3'b000, "R4 both full", {29'h0, d[18:16]}, 32'h0);
            end
            begin
                grab(1, fr);
                grab(1, fr2);
            end
        join
        chk(fr == frame_of(8'hA5), "R3 frame B first", {21'h0, fr}, {21'h0, frame_of(8'hA5)});
        chk(fr2 == frame_of(8'h3C), "R3 frame B second", {21'h0, fr2}, {21'h0, frame_of(8'h3C)});
        repeat (DIV) @(negedge clk);
        peek(8'hE8, d);
        chk(d == 32'h00060006, "R4 idle again", d, 32'h00060006);

        // R5 / R11: exhaustive receive sweep on channel A
        base = cnt_a;
        for (int v = 0; v < 256; v++) begin
            send(0, 8'(v), 1'b0, 1'b0);
            bus_read(8'hE8, d);
            bus_read(8'hE0, d2);
            chk(d[6:0] == 7'h07 && d2 == 32'(v), "R5 rx A", {d[7:0], 16'h0, d2[7:0]}, {8'h07, 16'h0, 8'(v)});
            peek(8'hE8, d);
            chk(d[0] == 1'b0, "R5 ready cleared", d, 32'h00060006);
        end
        chk(cnt_a - base == 256, "R11 rx events A", 32'(cnt_a - base), 32'd256);

        // R10: channel B receive lands in the upper field
        foreach (fr[i]) fr[i] = 1'b0;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] bv;
            bv = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h5A : 8'h81;
            send(1, bv, 1'b0, 1'b0);
            bus_read(8'hE8, d);
            chk(d == 32'h00070006, "R10 B ready", d, 32'h00070006);
            bus_read(8'hE4, d2);
            chk(d2 == {24'h0, bv}, "R10 B data", d2, {24'h0, bv});
        end

        // R6 framing error, byte kept; R12 error line; R9 clear
        send(0, 8'h11, 1'b0, 1'b1);
        repeat (DIV) @(negedge clk);
        bus_read(8'hE8, d);
        chk(d[6:4] == 3'b001 && irq_err, "R6 framing", {28'h0, irq_err, d[6:4]}, 32'h9);
        bus_read(8'hE0, d2);
        chk(d2 == 32'h11, "R6 byte kept", d2, 32'h11);
        bus_write(8'hE8, 32'h80);
        peek(8'hE8, d);
        chk(d[6:4] == 3'b000 && !irq_err, "R9 clear A", {28'h0, irq_err, d[6:4]}, 32'h0);

        // R7 parity on B, R8 overrun on A, then selective clears
        send(1, 8'h6E, 1'b1, 1'b0);
        peek(8'hE8, d);
        chk(d[22:20] == 3'b010 && irq_err, "R7 parity B", {28'h0, irq_err, d[22:20]}, 32'hA);
        send(0, 8'h01, 1'b0, 1'b0);
        send(0, 8'h02, 1'b0, 1'b0);
        peek(8'hE8, d);
        chk(d[6:4] == 3'b100, "R8 overrun flag", {29'h0, d[6:4]}, 32'h4);
        bus_read(8'hE0, d2);
        chk(d2 == 32'h02, "R8 newest kept", d2, 32'h02);
        bus_read(8'hE4, d2);
        bus_write(8'hE8, 32'h0);
        peek(8'hE8, d);
        chk(d[6:4] == 3'b100 && d[22:20] == 3'b010, "R9 no clear bit", d, 32'h00260046);
        bus_write(8'hE8, 32'h80);
        peek(8'hE8, d);
        chk(d[6:4] == 3'b000 && d[22:20] == 3'b010, "R9 A clear spares B", d, 32'h00260006);
        chk(irq_err == 1'b1, "R12 B still flagged", {31'h0, irq_err}, 32'h1);
        bus_write(8'hE8, 32'h0080_0000);
        peek(8'hE8, d);
        chk(d == 32'h00060006, "R9 clear B", d, 32'h00060006);
        chk(irq_err == 1'b0, "R12 error line low", {31'h0, irq_err}, 32'h0);

        // R1: unmapped offset
        base = cnt_a + cnt_b;
        bus_write(8'hEC, 32'hFFFF_FF55);
        for (int i = 0; i < 3 * DIV; i++) begin
            @(negedge clk);
            if (!(ser_tx_a && ser_tx_b)) begin
                chk(1'b0, "R1 no transmit", {30'h0, ser_tx_a, ser_tx_b}, 32'h3);
                break;
            end
        end
        bus_read(8'hEC, d);
        chk(d == 32'h0, "R1 unmapped reads zero", d, 32'h0);
        peek(8'hE8, d);
        chk(d == 32'h00060006 && (cnt_a + cnt_b) == base, "R1 no state change", d, 32'h00060006);

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end
endmodule